// File: doc/BRIEF.md
# Suspend Request Interrupt Delay Timer

This block turns two active-low hardware inputs, a suspend/resume push button and a battery-low indication, into one management interrupt request. Both inputs are brought into the clock domain and then share a single down-counter. The delay gives bus masters or a docking bridge time to finish their current work before the interrupt handler runs. A global enable and one enable per source decide which inputs may start the count. A separate bypass lets a battery-low condition raise the request at once, without the delay.

The count continues while a button request is latched or while battery-low is asserted and enabled. When battery-low goes away before expiry and no button request is latched, the count holds its value. It continues when battery-low returns or when the button is pressed. The request stays high until software pulses the clear input. The clear also reloads the counter from a programmable reload register. Two status bits record which source or sources caused the pending request. Nothing is started or counted while the system is in suspend.

Top module: `sreq_smi_delay`

## Requirements
- R1: After a synchronous reset, smi_req, stat_btn and stat_bat are 0, all control enables are 0, and the reload register and the counter both hold the parameter RLD_RST.
- R2: While the global enable (ctl_wdata bit 0) is 0, neither input raises smi_req, whatever the per-source enables hold.
- R3: With the global enable at 1, an input whose own enable is 0 never starts or advances the count. The button enable is bit 1 and the battery enable is bit 2.
- R4: The button is captured on its falling edge after a two-flop synchronizer, so a held button starts the count only once. smi_req rises on the clock edge numbered max(N,1)+2 after the input changes, where N is the counter value at the start.
- R5: An enabled low level on batlow_n advances the same shared counter and follows the same edge count as R4.
- R6: If battery-low negates before expiry and no button request is latched, the counter holds its value. It continues from that value when battery-low reasserts or when the button is pressed.
- R7: With the bypass enable (bit 3) at 1, an enabled battery-low raises smi_req on the third clock edge after the input changes.
- R8: While in_suspend is 1, neither input starts the count, advances it or raises smi_req.
- R9: smi_req stays high until smi_clr is sampled high, which clears it and reloads the counter from the reload register. A reload write while no count has started also loads the counter.
- R10: When smi_req rises, stat_btn is 1 if a button request took part and stat_bat is 1 if battery-low took part. Both bits clear with smi_req.
- R11: A button falling edge that reaches the capture stage in the same cycle that smi_clr is sampled is ignored, because a request is still pending in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_n | input | 1 | Suspend/resume button, active low, asynchronous |
| batlow_n | input | 1 | Battery-low, active low, asynchronous |
| in_suspend | input | 1 | System is suspended; blocks all requests |
| ctl_we | input | 1 | Write strobe for the control enables |
| ctl_wdata | input | 4 | bit0 global, bit1 button, bit2 battery, bit3 bypass |
| rld_we | input | 1 | Write strobe for the reload register |
| rld_wdata | input | CNT_W | Reload value |
| smi_clr | input | 1 | Clears the pending request and reloads the counter |
| smi_req | output | 1 | Management interrupt request, held until cleared |
| stat_btn | output | 1 | Button took part in the pending request |
| stat_bat | output | 1 | Battery-low took part in the pending request |

## Verification
The risky overlap is a clear and a fresh button capture landing on the same clock edge. The bench first raises a request through the bypass path. It then presses the button and times smi_clr so that the synchronized falling edge is sampled on the clearing edge. The check passes if the request drops and stays low for many cycles afterwards, which shows that the edge was dropped and not latched into a new count.

// File: rtl/sreq_pkg.sv
package sreq_pkg;
  localparam int CTL_W = 4;
  localparam int SRC_N = 2;
  localparam int SRC_BTN = 0;
  localparam int SRC_BAT = 1;

  typedef struct packed {
    logic byp;
    logic bat_en;
    logic btn_en;
    logic glb;
  } ctl_t;
endpackage

// File: rtl/sreq_sync.sv
module sreq_sync #(
  parameter int W = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_n,
  output logic [W-1:0] act,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] act_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
      act_prev <= '0;
    end else begin
      stg[0] <= in_n;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      act_prev <= act;
    end
  end

  assign act  = ~stg[STAGES-1];
  assign fall = act & ~act_prev;
endmodule

// File: rtl/sreq_ctlregs.sv
module sreq_ctlregs
  import sreq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int RLD_RST = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             rld_we,
  input  logic [CNT_W-1:0] rld_wdata,
  output ctl_t             ctl_q,
  output logic [CNT_W-1:0] rld_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      rld_q <= CNT_W'(RLD_RST);
    end else begin
      if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
      if (rld_we) rld_q <= rld_wdata;
    end
  end
endmodule

// File: rtl/sreq_dtimer.sv
module sreq_dtimer #(
  parameter int CNT_W = 16,
  parameter int RLD_RST = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic [CNT_W-1:0] rld_q,
  input  logic             wr_load,
  input  logic [CNT_W-1:0] rld_wdata,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= CNT_W'(RLD_RST);
    else if (reload)  cnt_q <= rld_q;
    else if (wr_load) cnt_q <= rld_wdata;
    else if (dec)     cnt_q <= (cnt_q <= ONE) ? '0 : cnt_q - ONE;
  end
endmodule

// File: rtl/sreq_smi_delay.sv
module sreq_smi_delay
  import sreq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int RLD_RST = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_n,
  input  logic             batlow_n,
  input  logic             in_suspend,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             rld_we,
  input  logic [CNT_W-1:0] rld_wdata,
  input  logic             smi_clr,
  output logic             smi_req,
  output logic             stat_btn,
  output logic             stat_bat
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  ctl_t             ctl_q;
  logic [CNT_W-1:0] rld_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SRC_N-1:0] act, fall;
  logic             btn_req, bat_seen;
  logic             glb_en, live, btn_ok, bat_ok;
  logic             btn_start, bat_on, byp_hit, run, expire, started;

  sreq_sync #(.W(SRC_N), .STAGES(2)) u_sync (
    .clk (clk), .rst (rst),
    .in_n ({batlow_n, btn_n}),
    .act (act), .fall (fall)
  );

  sreq_ctlregs #(.CNT_W(CNT_W), .RLD_RST(RLD_RST)) u_regs (
    .clk (clk), .rst (rst),
    .ctl_we (ctl_we), .ctl_wdata (ctl_wdata),
    .rld_we (rld_we), .rld_wdata (rld_wdata),
    .ctl_q (ctl_q), .rld_q (rld_q)
  );

  assign glb_en    = ctl_q.glb;
  assign live      = glb_en & ~in_suspend & ~smi_req;
  assign btn_ok    = live & ctl_q.btn_en;
  assign bat_ok    = live & ctl_q.bat_en;
  assign btn_start = btn_ok & fall[SRC_BTN];
  assign bat_on    = bat_ok & act[SRC_BAT];
  assign byp_hit   = bat_on & ctl_q.byp;
  assign run       = btn_start | (live & btn_req) | bat_on;
  assign expire    = run & (cnt_q <= ONE);
  assign started   = btn_req | bat_seen;

  sreq_dtimer #(.CNT_W(CNT_W), .RLD_RST(RLD_RST)) u_tmr (
    .clk (clk), .rst (rst),
    .reload (smi_clr), .rld_q (rld_q),
    .wr_load (rld_we & ~started), .rld_wdata (rld_wdata),
    .dec (run), .cnt_q (cnt_q)
  );

  always_ff @(posedge clk) begin
    if (rst || smi_clr) begin
      smi_req  <= 1'b0;
      stat_btn <= 1'b0;
      stat_bat <= 1'b0;
      btn_req  <= 1'b0;
      bat_seen <= 1'b0;
    end else if (!smi_req) begin
      if (btn_start) btn_req  <= 1'b1;
      if (bat_on)    bat_seen <= 1'b1;
      if (expire || byp_hit) begin
        smi_req  <= 1'b1;
        stat_btn <= btn_req | btn_start;
        stat_bat <= bat_seen | bat_on;
      end
    end
  end
endmodule

// File: rtl/sreq_smi_delay_chk.sv
module sreq_smi_delay_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             glb_en,
  input logic             in_suspend,
  input logic             smi_clr,
  input logic             rld_we,
  input logic             smi_req,
  input logic             stat_btn,
  input logic             stat_bat,
  input logic [CNT_W-1:0] cnt_q
);
  AST_GLB_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && !smi_req) |=> !smi_req);                           // R2
  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (in_suspend && !smi_req) |=> !smi_req);                        // R8
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (smi_req && !smi_clr) |=> smi_req);                            // R9
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    smi_clr |=> (!smi_req && !stat_btn && !stat_bat));             // R10
  AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (!smi_clr && !rld_we) |=> (cnt_q <= $past(cnt_q)));            // R6
  AST_STAT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(smi_req) |-> (stat_btn || stat_bat));                    // R10
endmodule

bind sreq_smi_delay sreq_smi_delay_chk #(.CNT_W(CNT_W)) u_chk (
  .clk (clk), .rst (rst), .glb_en (glb_en), .in_suspend (in_suspend),
  .smi_clr (smi_clr), .rld_we (rld_we), .smi_req (smi_req),
  .stat_btn (stat_btn), .stat_bat (stat_bat), .cnt_q (cnt_q)
);

// File: tb/tb_sreq_smi_delay.sv
`timescale 1ns/1ps
module tb_sreq_smi_delay;
  localparam int CNT_W = 8;
  localparam int RLD0 = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_n = 1'b1, batlow_n = 1'b1, in_suspend = 1'b0;
  logic ctl_we = 1'b0, rld_we = 1'b0, smi_clr = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic [CNT_W-1:0] rld_wdata = '0;
  logic smi_req, stat_btn, stat_bat;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sreq_smi_delay #(.CNT_W(CNT_W), .RLD_RST(RLD0)) dut (
    .clk (clk), .rst (rst), .btn_n (btn_n), .batlow_n (batlow_n),
    .in_suspend (in_suspend), .ctl_we (ctl_we), .ctl_wdata (ctl_wdata),
    .rld_we (rld_we), .rld_wdata (rld_wdata), .smi_clr (smi_clr),
    .smi_req (smi_req), .stat_btn (stat_btn), .stat_bat (stat_bat)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    ctl_wdata = v; ctl_we = 1'b1; edges(1); ctl_we = 1'b0;
  endtask

  task automatic wr_rld(input int v);
    rld_wdata = CNT_W'(v); rld_we = 1'b1; edges(1); rld_we = 1'b0;
  endtask

  task automatic do_clr();
    smi_clr = 1'b1; edges(1); smi_clr = 1'b0;
  endtask

  task automatic quiet_for(input int n, input string what);
    for (int i = 0; i < n; i++) begin
      edges(1);
      chk(smi_req, 1'b0, what);
    end
  endtask

  task automatic t_reset();
    chk(smi_req, 1'b0, "R1 smi_req after reset");
    chk(stat_btn, 1'b0, "R1 stat_btn after reset");
    chk(stat_bat, 1'b0, "R1 stat_bat after reset");
  endtask

  task automatic t_button_once();
    wr_ctl(4'b0011);
    btn_n = 1'b0;
    edges(RLD0 + 1);
    chk(smi_req, 1'b0, "R4 R1 button one edge early");
    edges(1);
    chk(smi_req, 1'b1, "R4 R1 button expiry edge");
    chk(stat_btn, 1'b1, "R10 stat_btn button only");
    chk(stat_bat, 1'b0, "R10 stat_bat button only");
    do_clr();
    chk(smi_req, 1'b0, "R9 cleared");
    quiet_for(40, "R4 held button starts once");
    btn_n = 1'b1; edges(4);
  endtask

  task automatic t_battery();
    wr_ctl(4'b0101);
    wr_rld(5);
    batlow_n = 1'b0;
    edges(6);
    chk(smi_req, 1'b0, "R5 R9 battery one edge early");
    edges(1);
    chk(smi_req, 1'b1, "R5 R9 battery expiry edge");
    chk(stat_bat, 1'b1, "R10 stat_bat battery only");
    chk(stat_btn, 1'b0, "R10 stat_btn battery only");
    edges(10);
    chk(smi_req, 1'b1, "R9 request held");
    batlow_n = 1'b1; edges(4);
    do_clr();
  endtask

  task automatic t_pause_bat();
    wr_ctl(4'b0101);
    wr_rld(10);
    batlow_n = 1'b0; edges(5);
    batlow_n = 1'b1;
    quiet_for(30, "R6 paused count");
    batlow_n = 1'b0;
    edges(6);
    chk(smi_req, 1'b0, "R6 resume by battery early");
    edges(1);
    chk(smi_req, 1'b1, "R6 resume by battery expiry");
    batlow_n = 1'b1; edges(4);
    do_clr();
  endtask

  task automatic t_pause_btn();
    wr_ctl(4'b0111);
    batlow_n = 1'b0; edges(5);
    batlow_n = 1'b1;
    quiet_for(20, "R6 paused before button");
    btn_n = 1'b0;
    edges(6);
    chk(smi_req, 1'b0, "R6 resume by button early");
    edges(1);
    chk(smi_req, 1'b1, "R6 resume by button expiry");
    chk(stat_btn, 1'b1, "R10 both sources btn");
    chk(stat_bat, 1'b1, "R10 both sources bat");
    btn_n = 1'b1; edges(4);
    do_clr();
  endtask

  task automatic t_enables();
    wr_ctl(4'b0110);
    btn_n = 1'b0; batlow_n = 1'b0;
    quiet_for(40, "R2 global enable off");
    btn_n = 1'b1; batlow_n = 1'b1; edges(4);
    wr_ctl(4'b0011);
    batlow_n = 1'b0;
    quiet_for(40, "R3 battery source disabled");
    batlow_n = 1'b1; edges(4);
  endtask

  task automatic t_bypass();
    wr_ctl(4'b1101);
    batlow_n = 1'b0;
    edges(2);
    chk(smi_req, 1'b0, "R7 bypass early");
    edges(1);
    chk(smi_req, 1'b1, "R7 bypass immediate");
    chk(stat_bat, 1'b1, "R7 R10 bypass stat_bat");
    batlow_n = 1'b1; edges(4);
    do_clr();
  endtask

  task automatic t_suspend();
    wr_ctl(4'b0111);
    in_suspend = 1'b1;
    btn_n = 1'b0; batlow_n = 1'b0;
    quiet_for(40, "R8 suspend blocks");
    btn_n = 1'b1; batlow_n = 1'b1; edges(4);
    in_suspend = 1'b0; edges(1);
  endtask

  task automatic t_clr_collision();
    wr_ctl(4'b1101);
    batlow_n = 1'b0; edges(3);
    batlow_n = 1'b1; edges(4);
    chk(smi_req, 1'b1, "R11 request pending before collision");
    wr_ctl(4'b0011);
    btn_n = 1'b0; edges(2);
    smi_clr = 1'b1; edges(1); smi_clr = 1'b0;
    chk(smi_req, 1'b0, "R11 cleared on collision edge");
    quiet_for(30, "R11 button edge in clear cycle ignored");
    btn_n = 1'b1; edges(4);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    edges(3);
    rst = 1'b0;
    edges(1);
    t_reset();
    t_button_once();
    t_battery();
    t_pause_bat();
    t_pause_btn();
    t_enables();
    t_bypass();
    t_suspend();
    t_clr_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule